// File: doc/BRIEF.md
# Shared Two-Port Memory with Cross-Port Message Flags

This block is a memory that two agents, called left and right, share through two complete access ports on one common clock. Each port can read or write any location in every cycle, independently of the other. Reads are synchronous. The read result appears one cycle after the request. When the other port writes the same location in the same cycle, the read returns the value stored before that write. When both ports write one location together, the left port's data is kept.

The two highest locations also act as message slots between the agents. The top location belongs to the right port. The location just below it belongs to the left port. When one agent writes into the other agent's slot, the owner's interrupt output rises. The owner acknowledges the message by reading its own slot, and that read drops the interrupt. Each interrupt flag is a small two-state machine. Its states are MBX_EMPTY and MBX_FULL. The POST transition, a peer write to the slot, moves to MBX_FULL. The TAKE transition, an owner read of the slot, moves to MBX_EMPTY. When POST and TAKE happen in the same cycle, POST wins, so no message is dropped.

The address width is a parameter, and the message slots are always the two highest addresses. With a 14-bit address (16K x 8), the right port's slot is 0x3FFF and the left port's slot is 0x3FFE.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: Reset clears both interrupt outputs (both flags go to MBX_EMPTY). Reset does not initialise the memory contents.
- R2: A port access with cs=1 and we=1 writes wdata at addr. An access with cs=1 and we=0 is a read, and its rdata is valid after the next rising clock edge. rdata keeps its value in cycles in which that port does not read. Data written through either port can be read through the other.
- R3: A read returns the value stored before a write to the same address in the same cycle by the other port.
- R4: If both ports write the same address in the same cycle, the left port's data is stored. Writes to different addresses in the same cycle are both stored.
- R5: A right-port write to address 2^ADDR_W-2 (the left slot) sets l_irq from the next cycle. A left-port write to address 2^ADDR_W-1 (the right slot) sets r_irq from the next cycle. The written data is stored in the slot. A set flag stays set until it is cleared.
- R6: A left-port read of the left slot clears l_irq from the next cycle, and a right-port read of the right slot clears r_irq. A read of the other port's slot leaves that flag unchanged.
- R7: A port writing to its own slot stores the data and changes neither interrupt.
- R8: If a POST and a TAKE of the same flag happen in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the interrupt flags |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_cs | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_rdata | output | DATA_W | Left port registered read data |
| l_irq | output | 1 | Left port interrupt, high while a message waits in the left slot |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_cs | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_rdata | output | DATA_W | Right port registered read data |
| r_irq | output | 1 | Right port interrupt, high while a message waits in the right slot |

## Verification
The hardest situation to create is a POST and a TAKE of one flag landing in the same clock edge. It needs the flag already set, then the peer's slot write and the owner's slot read issued together. The bench first posts a message, then drives both ports in one cycle. It checks that the owner reads the old message and that the interrupt stays high. A further read then returns the new message and clears the flag. Collisions are reached the same way: both ports are driven at one address in a single cycle, and the result is read back afterwards through a port.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int NPORT = 2;
    localparam int PORT_L = 0;
    localparam int PORT_R = 1;

    typedef enum logic {
        MBX_EMPTY = 1'b0,
        MBX_FULL  = 1'b1
    } mbx_state_e;

    typedef struct packed {
        logic post;
        logic take;
    } mbx_evt_t;

endpackage

// File: rtl/dpm_store.sv
module dpm_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              cs    [dpm_pkg::NPORT],
    input  logic              we    [dpm_pkg::NPORT],
    input  logic [ADDR_W-1:0] addr  [dpm_pkg::NPORT],
    input  logic [DATA_W-1:0] wdata [dpm_pkg::NPORT],
    output logic [DATA_W-1:0] rdata [dpm_pkg::NPORT]
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q [dpm_pkg::NPORT];

    // Writes are issued from the highest port index down to index 0.
    // The last nonblocking update wins, so the left port has priority.
    always_ff @(posedge clk) begin
        for (int p = dpm_pkg::NPORT - 1; p >= 0; p--) begin
            if (cs[p] && we[p]) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    // Read-first: the array is sampled before this edge's writes land.
    always_ff @(posedge clk) begin
        for (int p = 0; p < dpm_pkg::NPORT; p++) begin
            if (cs[p] && !we[p]) begin
                rdata_q[p] <= mem[addr[p]];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < dpm_pkg::NPORT; p++) begin
            rdata[p] = rdata_q[p];
        end
    end

endmodule

// File: rtl/dpm_mbx_decode.sv
module dpm_mbx_decode #(
    parameter int ADDR_W = 11,
    parameter int BOX_ADDR = 0
) (
    input  logic              own_cs,
    input  logic              own_we,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              peer_cs,
    input  logic              peer_we,
    input  logic [ADDR_W-1:0] peer_addr,
    output dpm_pkg::mbx_evt_t evt
);
    localparam logic [ADDR_W-1:0] BOX = ADDR_W'(BOX_ADDR);

    logic own_hit;
    logic peer_hit;

    always_comb begin
        own_hit  = own_cs && (own_addr == BOX);
        peer_hit = peer_cs && (peer_addr == BOX);
        // A message is posted only by the peer writing this slot.
        evt.post = peer_hit && peer_we;
        // Only the owner reading its slot acknowledges the message.
        evt.take = own_hit && !own_we;
    end

endmodule

// File: rtl/dpm_mbx_fsm.sv
module dpm_mbx_fsm (
    input  logic              clk,
    input  logic              rst_n,
    input  dpm_pkg::mbx_evt_t evt,
    output logic              irq
);
    import dpm_pkg::*;

    mbx_state_e state_q;
    mbx_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MBX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MBX_EMPTY: begin
                if (evt.post) begin
                    state_d = MBX_FULL;           // POST
                end
            end
            MBX_FULL: begin
                if (evt.take && !evt.post) begin
                    state_d = MBX_EMPTY;          // TAKE, loses to POST
                end
            end
        endcase
    end

    always_comb begin
        irq = (state_q == MBX_FULL);
    end

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_cs,
    input  logic              l_we,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_cs,
    input  logic              r_we,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq
);
    import dpm_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int BOX_L = DEPTH - 2;
    localparam int BOX_R = DEPTH - 1;

    logic              cs_a    [NPORT];
    logic              we_a    [NPORT];
    logic [ADDR_W-1:0] addr_a  [NPORT];
    logic [DATA_W-1:0] wdata_a [NPORT];
    logic [DATA_W-1:0] rdata_a [NPORT];
    logic              irq_a   [NPORT];

    always_comb begin
        cs_a[PORT_L]    = l_cs;
        we_a[PORT_L]    = l_we;
        addr_a[PORT_L]  = l_addr;
        wdata_a[PORT_L] = l_wdata;
        cs_a[PORT_R]    = r_cs;
        we_a[PORT_R]    = r_we;
        addr_a[PORT_R]  = r_addr;
        wdata_a[PORT_R] = r_wdata;
    end

    dpm_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk  (clk),
        .cs   (cs_a),
        .we   (we_a),
        .addr (addr_a),
        .wdata(wdata_a),
        .rdata(rdata_a)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_box
        localparam int PEER = NPORT - 1 - p;
        localparam int OWN_BOX = (p == PORT_L) ? BOX_L : BOX_R;

        mbx_evt_t evt;

        dpm_mbx_decode #(
            .ADDR_W  (ADDR_W),
            .BOX_ADDR(OWN_BOX)
        ) u_dec (
            .own_cs   (cs_a[p]),
            .own_we   (we_a[p]),
            .own_addr (addr_a[p]),
            .peer_cs  (cs_a[PEER]),
            .peer_we  (we_a[PEER]),
            .peer_addr(addr_a[PEER]),
            .evt      (evt)
        );

        dpm_mbx_fsm u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt),
            .irq  (irq_a[p])
        );
    end

    always_comb begin
        l_rdata = rdata_a[PORT_L];
        r_rdata = rdata_a[PORT_R];
        l_irq   = irq_a[PORT_L];
        r_irq   = irq_a[PORT_R];
    end

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_cs,
    input logic              l_we,
    input logic              l_irq,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_cs,
    input logic              r_we,
    input logic              r_irq
);
    localparam logic [ADDR_W-1:0] SLOT_R = '1;
    localparam logic [ADDR_W-1:0] SLOT_L = SLOT_R - ADDR_W'(1);

    logic l_post, l_take, r_post, r_take;
    assign l_post = r_cs && r_we && (r_addr == SLOT_L);
    assign l_take = l_cs && !l_we && (l_addr == SLOT_L);
    assign r_post = l_cs && l_we && (l_addr == SLOT_R);
    assign r_take = r_cs && !r_we && (r_addr == SLOT_R);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!l_irq && !r_irq));

    p_left_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
        l_post |=> l_irq);
    p_right_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_post |=> r_irq);

    p_left_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_take && !l_post) |=> !l_irq);
    p_right_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_take && !r_post) |=> !r_irq);

    p_left_own_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cs && l_we && (l_addr == SLOT_L) && !l_irq && !l_post) |=> !l_irq);
    p_right_own_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_cs && r_we && (r_addr == SLOT_R) && !r_irq && !r_post) |=> !r_irq);

    p_left_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_irq) |-> $past(l_post));
    p_left_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_irq) |-> $past(l_take));
    p_right_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_irq) |-> $past(r_post));
    p_right_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_irq) |-> $past(r_take));

    p_left_post_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_post && l_take) |=> l_irq);
    p_right_post_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_post && r_take) |=> r_irq);

endmodule

bind dpm_mailbox_ram dpm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .l_addr(l_addr),
    .l_cs  (l_cs),
    .l_we  (l_we),
    .l_irq (l_irq),
    .r_addr(r_addr),
    .r_cs  (r_cs),
    .r_we  (r_we),
    .r_irq (r_irq)
);

// File: tb/tb_dpm_mailbox_ram.sv
module tb_dpm_mailbox_ram;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] SLOT_R = '1;
    localparam logic [ADDR_W-1:0] SLOT_L = SLOT_R - ADDR_W'(1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
    logic l_cs = 1'b0, l_we = 1'b0, r_cs = 1'b0, r_we = 1'b0;
    logic [DATA_W-1:0] l_rdata, r_rdata;
    logic l_irq, r_irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_cs(l_cs), .l_we(l_we),
        .l_rdata(l_rdata), .l_irq(l_irq),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_cs(r_cs), .r_we(r_we),
        .r_rdata(r_rdata), .r_irq(r_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive both ports, pass one rising edge, sample 1 time unit later.
    task automatic step(input logic lc, input logic lw, input logic [ADDR_W-1:0] la,
                        input logic [DATA_W-1:0] ld,
                        input logic rc, input logic rw, input logic [ADDR_W-1:0] ra,
                        input logic [DATA_W-1:0] rd);
        l_cs = lc; l_we = lw; l_addr = la; l_wdata = ld;
        r_cs = rc; r_we = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        #1;
        l_cs = 1'b0; l_we = 1'b0; r_cs = 1'b0; r_we = 1'b0;
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 0, 0, '0, '0);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        idle();
        idle();
        chk("R1", "l_irq in reset", {7'd0, l_irq}, 8'd0);
        chk("R1", "r_irq in reset", {7'd0, r_irq}, 8'd0);
        rst_n = 1'b1;
        idle();
        chk("R1", "l_irq after reset", {7'd0, l_irq}, 8'd0);
        chk("R1", "r_irq after reset", {7'd0, r_irq}, 8'd0);
    endtask

    task automatic t_basic_r2();
        step(1, 1, 11'h010, 8'hA5, 0, 0, '0, '0);
        step(0, 0, '0, '0, 1, 0, 11'h010, '0);
        chk("R2", "right reads left write", r_rdata, 8'hA5);
        idle();
        chk("R2", "rdata held when idle", r_rdata, 8'hA5);
        step(0, 0, '0, '0, 1, 1, 11'h020, 8'h3C);
        chk("R2", "rdata held during write", r_rdata, 8'hA5);
        step(1, 0, 11'h020, '0, 0, 0, '0, '0);
        chk("R2", "left reads right write", l_rdata, 8'h3C);
    endtask

    task automatic t_read_old_r3();
        step(1, 1, 11'h030, 8'h11, 0, 0, '0, '0);
        step(1, 1, 11'h030, 8'h22, 1, 0, 11'h030, '0);
        chk("R3", "read during peer write gives old", r_rdata, 8'h11);
        step(0, 0, '0, '0, 1, 0, 11'h030, '0);
        chk("R3", "next read gives new", r_rdata, 8'h22);
    endtask

    task automatic t_collide_r4();
        step(1, 1, 11'h040, 8'h77, 1, 1, 11'h040, 8'h88);
        step(1, 0, 11'h040, '0, 0, 0, '0, '0);
        chk("R4", "same-address writes keep left", l_rdata, 8'h77);
        step(1, 1, 11'h041, 8'h01, 1, 1, 11'h042, 8'h02);
        step(1, 0, 11'h041, '0, 1, 0, 11'h042, '0);
        chk("R4", "left different address", l_rdata, 8'h01);
        chk("R4", "right different address", r_rdata, 8'h02);
    endtask

    task automatic t_mailbox_r5_r6();
        step(0, 0, '0, '0, 1, 1, SLOT_L, 8'h5A);
        chk("R5", "l_irq after right posts", {7'd0, l_irq}, 8'd1);
        chk("R5", "r_irq untouched", {7'd0, r_irq}, 8'd0);
        idle();
        chk("R5", "l_irq stays set", {7'd0, l_irq}, 8'd1);
        step(0, 0, '0, '0, 1, 0, SLOT_L, '0);
        chk("R6", "peer read of left slot keeps l_irq", {7'd0, l_irq}, 8'd1);
        step(1, 0, SLOT_L, '0, 0, 0, '0, '0);
        chk("R5", "left reads message", l_rdata, 8'h5A);
        chk("R6", "l_irq cleared by owner read", {7'd0, l_irq}, 8'd0);
        step(1, 1, SLOT_R, 8'hC3, 0, 0, '0, '0);
        chk("R5", "r_irq after left posts", {7'd0, r_irq}, 8'd1);
        step(1, 0, SLOT_R, '0, 0, 0, '0, '0);
        chk("R6", "peer read of right slot keeps r_irq", {7'd0, r_irq}, 8'd1);
        step(0, 0, '0, '0, 1, 0, SLOT_R, '0);
        chk("R5", "right reads message", r_rdata, 8'hC3);
        chk("R6", "r_irq cleared by owner read", {7'd0, r_irq}, 8'd0);
    endtask

    task automatic t_own_write_r7();
        step(1, 1, SLOT_L, 8'h99, 1, 1, SLOT_R, 8'h66);
        chk("R7", "own write no l_irq", {7'd0, l_irq}, 8'd0);
        chk("R7", "own write no r_irq", {7'd0, r_irq}, 8'd0);
        step(1, 0, SLOT_L, '0, 1, 0, SLOT_R, '0);
        chk("R7", "left own slot stored", l_rdata, 8'h99);
        chk("R7", "right own slot stored", r_rdata, 8'h66);
    endtask

    task automatic t_post_wins_r8();
        step(0, 0, '0, '0, 1, 1, SLOT_L, 8'h10);
        step(1, 0, SLOT_L, '0, 1, 1, SLOT_L, 8'h20);
        chk("R8", "owner read returns first message", l_rdata, 8'h10);
        chk("R8", "l_irq kept on post+take", {7'd0, l_irq}, 8'd1);
        step(1, 0, SLOT_L, '0, 0, 0, '0, '0);
        chk("R8", "second message readable", l_rdata, 8'h20);
        chk("R8", "l_irq cleared afterwards", {7'd0, l_irq}, 8'd0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset_r1();
        t_basic_r2();
        t_read_old_r3();
        t_collide_r4();
        t_mailbox_r5_r6();
        t_own_write_r7();
        t_post_wins_r8();
        idle();
        finish_run();
    end

endmodule